// File: doc/BRIEF.md
# Prioritized Interrupt Request Controller

This block collects interrupt requests for a 16-bit processor core and presents the most urgent one. There are sixteen priority levels. Level 0 belongs to the power-down input. Levels 1 to 6 belong to six user inputs. Levels 7 and 8 belong to two I/O expansion inputs. Levels 9 to 15 take single-cycle set pulses from sources inside the core, such as the timers and the fault summary.

The power-down and user inputs can be captured in one of two ways, chosen by a single configuration bit. In edge mode a rising edge sets a sticky pending bit. In level mode the pending bit follows the input. The I/O expansion inputs are always active-high level requests. Every external input passes through a synchronizer before it is used.

A mask register and a global enable decide which pending levels reach the core. The power-down level ignores both. The core sees a request-valid flag and a 4-bit level. It answers with an acknowledge that carries the level it has taken. The acknowledge clears a sticky pending bit.

Top module: `irq_prio_ctrl`

## Requirements
- R1: Reset clears the pending bits, the mask and the global enable, and selects edge mode. After reset `pend_o` is 0, `irq_valid_o` is 0, and only level 0 can raise a request.
- R2: Levels map to sources in a fixed way. Level 0 is `pwrdn_irq_i`. Levels 1 to 6 are `usr_irq_i[0..5]`. Levels 7 and 8 are `iol_irq_i[0..1]`. Levels 9 to 15 are `int_irq_i[0..6]`. Bit n of `pend_o` is the pending state of level n.
- R3: When at least one level is eligible, `irq_valid_o` is 1 and `irq_lvl_o` gives the lowest-numbered eligible level. A level is eligible when it is pending and not blocked. When no level is eligible, `irq_valid_o` is 0.
- R4: Level 0 is never blocked. A pending level 0 gives `irq_valid_o`=1 and `irq_lvl_o`=0, whatever the mask and the enable hold.
- R5: When the global enable is 0, levels 1 to 15 are blocked. They are still recorded in `pend_o`.
- R6: Mask bit n (`cfg_mask_i[n]`, n = 1..15) set to 1 blocks level n. A blocked level still records in `pend_o`.
- R7: Edge mode is `cfg_level_mode_i`=0. In this mode a rising edge on the power-down input or on a user input sets its pending bit. The bit stays set after the input falls. An acknowledge of that level clears it one cycle later.
- R8: Level mode is `cfg_level_mode_i`=1. In this mode the pending bits of the power-down and user inputs follow the synchronized inputs, and an acknowledge has no effect on them.
- R9: The I/O expansion levels follow their synchronized inputs in both modes, and an acknowledge has no effect on them.
- R10: If `int_irq_i[k]` is high at a clock edge, level 9+k is set pending at that edge. The bit stays set until that level is acknowledged. If a set and an acknowledge of the same level arrive in the same cycle, the level stays pending.
- R11: A change on an external input is first visible on `pend_o` after the third rising edge that follows it. That is two synchronizer stages plus the pending register. A level held for one clock period is always captured.
- R12: When `cfg_we_i` is 1 at a clock edge, that edge loads the mode, the enable and the mask together. The new values govern the outputs from that edge onward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pwrdn_irq_i | input | 1 | Power-down request, level 0 |
| usr_irq_i | input | 6 | User requests, levels 1 to 6 |
| iol_irq_i | input | 2 | I/O expansion requests, levels 7 and 8, active high |
| int_irq_i | input | 7 | Internal set pulses, levels 9 to 15 |
| cfg_we_i | input | 1 | Loads mode, enable and mask |
| cfg_level_mode_i | input | 1 | 0 selects edge capture, 1 selects level capture |
| cfg_en_i | input | 1 | Global enable for levels 1 to 15 |
| cfg_mask_i | input | 15 | Bit n blocks level n (bits 15 down to 1) |
| ack_i | input | 1 | Core acknowledges a level |
| ack_lvl_i | input | 4 | Level being acknowledged |
| irq_valid_o | output | 1 | An eligible request exists |
| irq_lvl_o | output | 4 | Highest-priority eligible level |
| pend_o | output | 16 | Pending bit per level |

## Verification
If a pending bit is lost or stuck, it shows on `pend_o` at the next clock edge. If it belongs to the highest eligible level, it also moves `irq_lvl_o` or `irq_valid_o` at that same edge. If the mask, enable or mode registers hold a wrong value, the result appears on the very next comparison after the write: a level is presented that should be blocked, a level is missing, or a bit stays set when it should follow the input. Errors in the synchronizer depth or in the edge detector show up as a request that appears one edge too early or too late, or not at all. The bench compares against a model every cycle, so it catches these at the exact edge.

// File: rtl/irq_pkg.sv
package irq_pkg;
  typedef enum logic {
    CAP_EDGE  = 1'b0,
    CAP_LEVEL = 1'b1
  } cap_mode_e;

  localparam int unsigned DEF_NUM_LVL = 16;
  localparam int unsigned DEF_NUM_USR = 6;
  localparam int unsigned DEF_NUM_IOL = 2;
  localparam int unsigned DEF_SYNC    = 2;
endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
  parameter int unsigned W      = 1,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < STAGES; i++) stg_q[i] <= '0;
    end else begin
      stg_q[0] <= d_i;
      for (int i = 1; i < STAGES; i++) stg_q[i] <= stg_q[i-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/irq_pend.sv
module irq_pend
  import irq_pkg::*;
#(
  parameter int unsigned NUM_LVL = DEF_NUM_LVL,
  parameter int unsigned NUM_USR = DEF_NUM_USR,
  parameter int unsigned NUM_IOL = DEF_NUM_IOL,
  localparam int unsigned LVL_W   = $clog2(NUM_LVL),
  localparam int unsigned NUM_MOD = 1 + NUM_USR,
  localparam int unsigned NUM_EXT = NUM_MOD + NUM_IOL,
  localparam int unsigned NUM_INT = NUM_LVL - NUM_EXT
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  cap_mode_e          mode_i,
  input  logic [NUM_EXT-1:0] ext_lvl_i,
  input  logic [NUM_MOD-1:0] ext_rise_i,
  input  logic [NUM_INT-1:0] int_set_i,
  input  logic               ack_i,
  input  logic [LVL_W-1:0]   ack_lvl_i,
  output logic [NUM_LVL-1:0] pend_o
);
  logic [NUM_LVL-1:0] pend_q, pend_d;

  for (genvar g = 0; g < NUM_LVL; g++) begin : g_lvl
    logic ack_hit;
    assign ack_hit = ack_i && (ack_lvl_i == LVL_W'(g));
    if (g < NUM_MOD) begin : g_modal
      assign pend_d[g] = (mode_i == CAP_LEVEL) ? ext_lvl_i[g]
                       : (ext_rise_i[g] | (pend_q[g] & ~ack_hit));
    end else if (g < NUM_EXT) begin : g_level
      assign pend_d[g] = ext_lvl_i[g];
    end else begin : g_int
      // set beats a same-cycle acknowledge
      assign pend_d[g] = int_set_i[g-NUM_EXT] | (pend_q[g] & ~ack_hit);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pend_q <= '0;
    else         pend_q <= pend_d;
  end

  assign pend_o = pend_q;
endmodule

// File: rtl/irq_prio_enc.sv
module irq_prio_enc #(
  parameter int unsigned N = 16,
  localparam int unsigned W = $clog2(N)
) (
  input  logic [N-1:0] req_i,
  output logic         valid_o,
  output logic [W-1:0] idx_o
);
  always_comb begin
    idx_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req_i[i]) idx_o = W'(i);
    end
  end

  assign valid_o = |req_i;
endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl
  import irq_pkg::*;
#(
  parameter int unsigned NUM_LVL     = DEF_NUM_LVL,
  parameter int unsigned NUM_USR     = DEF_NUM_USR,
  parameter int unsigned NUM_IOL     = DEF_NUM_IOL,
  parameter int unsigned SYNC_STAGES = DEF_SYNC,
  localparam int unsigned LVL_W   = $clog2(NUM_LVL),
  localparam int unsigned NUM_MOD = 1 + NUM_USR,
  localparam int unsigned NUM_EXT = NUM_MOD + NUM_IOL,
  localparam int unsigned NUM_INT = NUM_LVL - NUM_EXT
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               pwrdn_irq_i,
  input  logic [NUM_USR-1:0] usr_irq_i,
  input  logic [NUM_IOL-1:0] iol_irq_i,
  input  logic [NUM_INT-1:0] int_irq_i,
  input  logic               cfg_we_i,
  input  logic               cfg_level_mode_i,
  input  logic               cfg_en_i,
  input  logic [NUM_LVL-1:1] cfg_mask_i,
  input  logic               ack_i,
  input  logic [LVL_W-1:0]   ack_lvl_i,
  output logic               irq_valid_o,
  output logic [LVL_W-1:0]   irq_lvl_o,
  output logic [NUM_LVL-1:0] pend_o
);
  cap_mode_e          mode_q;
  logic               en_q;
  logic [NUM_LVL-1:1] mask_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= CAP_EDGE;
      en_q   <= 1'b0;
      mask_q <= '0;
    end else if (cfg_we_i) begin
      mode_q <= cap_mode_e'(cfg_level_mode_i);
      en_q   <= cfg_en_i;
      mask_q <= cfg_mask_i;
    end
  end

  // bit order matches level numbering
  logic [NUM_EXT-1:0] ext_raw, ext_s;
  assign ext_raw = {iol_irq_i, usr_irq_i, pwrdn_irq_i};

  irq_sync #(.W(NUM_EXT), .STAGES(SYNC_STAGES)) i_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (ext_raw),
    .q_o   (ext_s)
  );

  logic [NUM_MOD-1:0] mod_prev_q, mod_rise;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) mod_prev_q <= '0;
    else         mod_prev_q <= ext_s[NUM_MOD-1:0];
  end
  assign mod_rise = ext_s[NUM_MOD-1:0] & ~mod_prev_q;

  logic [NUM_LVL-1:0] pend;
  irq_pend #(.NUM_LVL(NUM_LVL), .NUM_USR(NUM_USR), .NUM_IOL(NUM_IOL)) i_pend (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .mode_i    (mode_q),
    .ext_lvl_i (ext_s),
    .ext_rise_i(mod_rise),
    .int_set_i (int_irq_i),
    .ack_i     (ack_i),
    .ack_lvl_i (ack_lvl_i),
    .pend_o    (pend)
  );

  // level 0 is never blocked
  logic [NUM_LVL-1:0] blocked, eligible;
  assign blocked  = {mask_q | {(NUM_LVL-1){~en_q}}, 1'b0};
  assign eligible = pend & ~blocked;

  irq_prio_enc #(.N(NUM_LVL)) i_enc (
    .req_i  (eligible),
    .valid_o(irq_valid_o),
    .idx_o  (irq_lvl_o)
  );

  assign pend_o = pend;
endmodule

// File: rtl/irq_prio_ctrl_chk.sv
module irq_prio_ctrl_chk #(
  parameter int unsigned NUM_LVL = 16,
  parameter int unsigned NUM_EXT = 9,
  localparam int unsigned LVL_W   = $clog2(NUM_LVL),
  localparam int unsigned NUM_INT = NUM_LVL - NUM_EXT
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic [NUM_INT-1:0] int_irq_i,
  input logic               cfg_we_i,
  input logic               cfg_en_i,
  input logic [NUM_LVL-1:1] cfg_mask_i,
  input logic               ack_i,
  input logic [LVL_W-1:0]   ack_lvl_i,
  input logic               irq_valid_o,
  input logic [LVL_W-1:0]   irq_lvl_o,
  input logic [NUM_LVL-1:0] pend_o,
  input logic               en_q,
  input logic [NUM_LVL-1:1] mask_q
);
  logic [NUM_LVL-1:0] set_vec, elig, below;
  assign set_vec = {int_irq_i, {NUM_EXT{1'b0}}};
  assign elig    = pend_o & ~{mask_q | {(NUM_LVL-1){~en_q}}, 1'b0};
  assign below   = (NUM_LVL'(1) << irq_lvl_o) - NUM_LVL'(1);

  p_pwr_first_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pend_o[0] |-> (irq_valid_o && irq_lvl_o == '0));

  p_valid_pending_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_valid_o |-> pend_o[irq_lvl_o]);

  p_lowest_first_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_valid_o |-> ((elig & below) == '0));

  p_disabled_quiet_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_q && !pend_o[0]) |-> !irq_valid_o);

  p_masked_quiet_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_valid_o && irq_lvl_o != '0) |-> !mask_q[irq_lvl_o]);

  p_int_ack_clear_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_i && ack_lvl_i >= LVL_W'(NUM_EXT) && !set_vec[ack_lvl_i])
      |=> !pend_o[$past(ack_lvl_i)]);

  p_int_set_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int_irq_i[0] |=> pend_o[NUM_EXT]);

  p_cfg_load_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_we_i |=> (en_q == $past(cfg_en_i) && mask_q == $past(cfg_mask_i)));
endmodule

bind irq_prio_ctrl irq_prio_ctrl_chk #(.NUM_LVL(NUM_LVL), .NUM_EXT(NUM_EXT)) i_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .int_irq_i  (int_irq_i),
  .cfg_we_i   (cfg_we_i),
  .cfg_en_i   (cfg_en_i),
  .cfg_mask_i (cfg_mask_i),
  .ack_i      (ack_i),
  .ack_lvl_i  (ack_lvl_i),
  .irq_valid_o(irq_valid_o),
  .irq_lvl_o  (irq_lvl_o),
  .pend_o     (pend_o),
  .en_q       (en_q),
  .mask_q     (mask_q)
);

// File: tb/test_irq_prio_ctrl.sv
`timescale 1ns/1ps
module test_irq_prio_ctrl;
  localparam int CYC = 8;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        pwrdn_irq_i = 1'b0;
  logic [5:0]  usr_irq_i = '0;
  logic [1:0]  iol_irq_i = '0;
  logic [6:0]  int_irq_i = '0;
  logic        cfg_we_i = 1'b0;
  logic        cfg_level_mode_i = 1'b0;
  logic        cfg_en_i = 1'b0;
  logic [15:1] cfg_mask_i = '0;
  logic        ack_i = 1'b0;
  logic [3:0]  ack_lvl_i = '0;
  logic        irq_valid_o;
  logic [3:0]  irq_lvl_o;
  logic [15:0] pend_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  always #(CYC/2) clk_i = ~clk_i;

  irq_prio_ctrl i_irq_prio_ctrl (.*);

  // reference model
  logic [8:0]  m_s1, m_s2;
  logic [6:0]  m_prev;
  logic [15:0] m_pend;
  logic        m_mode, m_en;
  logic [15:1] m_mask;

  function automatic logic [15:0] next_pend(logic [15:0] p);
    logic [15:0] n;
    for (int l = 0; l < 16; l++) begin
      logic hit;
      hit = ack_i && (ack_lvl_i == 4'(l));
      if (l < 7)      n[l] = m_mode ? m_s2[l] : ((m_s2[l] & ~m_prev[l]) | (p[l] & ~hit));
      else if (l < 9) n[l] = m_s2[l];
      else            n[l] = int_irq_i[l-9] | (p[l] & ~hit);
    end
    return n;
  endfunction

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_s1 <= '0; m_s2 <= '0; m_prev <= '0; m_pend <= '0;
      m_mode <= 1'b0; m_en <= 1'b0; m_mask <= '0;
    end else begin
      m_s1   <= {iol_irq_i, usr_irq_i, pwrdn_irq_i};
      m_s2   <= m_s1;
      m_prev <= m_s2[6:0];
      m_pend <= next_pend(m_pend);
      if (cfg_we_i) begin
        m_mode <= cfg_level_mode_i; m_en <= cfg_en_i; m_mask <= cfg_mask_i;
      end
    end
  end

  function automatic logic [15:0] exp_elig();
    return m_pend & ~{m_mask | {15{~m_en}}, 1'b0};
  endfunction

  function automatic logic [3:0] exp_lvl();
    logic [15:0] e;
    e = exp_elig();
    for (int l = 0; l < 16; l++) if (e[l]) return 4'(l);
    return 4'd0;
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic tick(int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic cfg(logic mode, logic en, logic [15:1] mask);
    cfg_level_mode_i = mode; cfg_en_i = en; cfg_mask_i = mask; cfg_we_i = 1'b1;
    tick(1);
    cfg_we_i = 1'b0;
  endtask

  task automatic ack(logic [3:0] lvl);
    ack_i = 1'b1; ack_lvl_i = lvl;
    tick(1);
    ack_i = 1'b0;
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
  endtask

  initial begin
    #(CYC * 150000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      summary();
      $finish;
    end
  end

  initial begin
    $urandom(1750);
    tick(3);
    rst_ni = 1'b1;
    tick(1);
    check("R1 pend", pend_o, 0);
    check("R1 valid", irq_valid_o, 0);

    usr_irq_i[0] = 1'b1;
    tick(2);
    check("R11 not yet", pend_o[1], 0);
    tick(1);
    check("R11 third edge", pend_o[1], 1);
    usr_irq_i[0] = 1'b0;
    tick(4);
    check("R7 sticky", pend_o, 16'h0002);
    check("R1 enable cleared", irq_valid_o, 0);

    cfg(1'b0, 1'b1, '0);
    check("R12 valid", irq_valid_o, 1);
    check("R12 lvl", irq_lvl_o, 1);

    int_irq_i[0] = 1'b1; iol_irq_i[1] = 1'b1;
    tick(1);
    int_irq_i[0] = 1'b0;
    tick(3);
    check("R2 map", pend_o, 16'h0302);
    check("R3 lowest", irq_lvl_o, 1);

    ack(4'd1);
    check("R7 ack clear", pend_o[1], 0);
    check("R3 next", irq_lvl_o, 8);

    begin
      logic [15:1] m;
      m = '0; m[8] = 1'b1;
      cfg(1'b0, 1'b1, m);
    end
    check("R6 skip masked", irq_lvl_o, 9);
    check("R6 still pend", pend_o, 16'h0300);

    ack(4'd8);
    check("R9 ack ignored", pend_o[8], 1);
    iol_irq_i[1] = 1'b0;
    tick(3);
    check("R9 follows", pend_o[8], 0);

    ack(4'd9);
    check("R10 ack clear", pend_o[9], 0);
    check("R3 none", irq_valid_o, 0);
    int_irq_i[6] = 1'b1;
    tick(1);
    check("R10 set", pend_o[15], 1);
    ack_i = 1'b1; ack_lvl_i = 4'd15;
    tick(1);
    ack_i = 1'b0; int_irq_i[6] = 1'b0;
    check("R10 set wins", pend_o[15], 1);
    ack(4'd15);
    check("R10 cleared", pend_o[15], 0);

    cfg(1'b0, 1'b0, '1);
    pwrdn_irq_i = 1'b1;
    tick(1);
    pwrdn_irq_i = 1'b0;
    tick(2);
    check("R4 valid", irq_valid_o, 1);
    check("R4 lvl", irq_lvl_o, 0);
    ack(4'd0);
    check("R7 pwr ack", pend_o[0], 0);

    cfg(1'b0, 1'b0, '0);
    int_irq_i[2] = 1'b1;
    tick(1);
    int_irq_i[2] = 1'b0;
    check("R5 recorded", pend_o[11], 1);
    check("R5 blocked", irq_valid_o, 0);

    cfg(1'b1, 1'b1, '0);
    check("R5 released", irq_lvl_o, 11);
    usr_irq_i[5] = 1'b1;
    tick(3);
    check("R8 follows high", pend_o[6], 1);
    check("R8 lvl", irq_lvl_o, 6);
    ack(4'd6);
    check("R8 ack ignored", pend_o[6], 1);
    usr_irq_i[5] = 1'b0;
    tick(3);
    check("R8 follows low", pend_o[6], 0);
    check("R8 back", irq_lvl_o, 11);
    ack(4'd11);

    for (int it = 0; it < 4000; it++) begin
      check("R2 pend model", pend_o, m_pend);
      check("R3 valid model", irq_valid_o, |exp_elig());
      if (|exp_elig()) check("R3 lvl model", irq_lvl_o, exp_lvl());
      for (int b = 0; b < 6; b++) if ($urandom_range(3) == 0) usr_irq_i[b] = ~usr_irq_i[b];
      for (int b = 0; b < 2; b++) if ($urandom_range(3) == 0) iol_irq_i[b] = ~iol_irq_i[b];
      if ($urandom_range(7) == 0) pwrdn_irq_i = ~pwrdn_irq_i;
      for (int b = 0; b < 7; b++) int_irq_i[b] = ($urandom_range(9) == 0);
      ack_i = ($urandom_range(2) == 0);
      ack_lvl_i = (irq_valid_o && $urandom_range(3) != 0) ? irq_lvl_o : 4'($urandom_range(15));
      cfg_we_i = ($urandom_range(47) == 0);
      cfg_level_mode_i = $urandom_range(1);
      cfg_en_i = ($urandom_range(4) != 0);
      cfg_mask_i = 15'($urandom) & 15'($urandom);
      tick(1);
    end

    done = 1;
    summary();
    $finish;
  end
endmodule